// File: doc/BRIEF.md
# ECP Peripheral Reverse-Cycle Transmitter

This block is the peripheral end of an ECP parallel link that sends bytes back to the host. A producer offers one byte at a time with a data/command flag on a valid/ready interface. The block checks that the host is asking for the reverse channel by holding the active-low reverse-request line low. If so, it acknowledges with its active-low reverse acknowledge and drives the byte onto the bidirectional data bus. It then runs the strobe interlock with the host: the peripheral strobe falls, the host raises its acknowledge, and the strobe rises. The host latches the byte on that rising edge and confirms receipt by dropping its acknowledge. After that the block releases the bus and the reverse acknowledge.

The entry is non-blocking. A byte offered while the host still holds the link in the forward direction is consumed at once and reported as refused, and no pin moves. If the host withdraws the reverse request while the block waits on the host acknowledge, the transfer is abandoned through the same turnaround path and reported as aborted. Each offered byte ends with exactly one one-cycle `done` pulse that carries a result code.

The two host inputs pass through a synchronizer of `SYNC_STAGES` flops. All pin outputs are registered from the next-state value, so they change only on clock edges and never glitch.

States: IDLE, REFUSE, CLAIM, PRESENT, STROBE, LATCH, TURN, FINISH. Transitions:
- IDLE to REFUSE on an offered byte while the synchronized request is high.
- IDLE to CLAIM on an offered byte while the synchronized request is low.
- REFUSE to IDLE.
- CLAIM to PRESENT.
- PRESENT to STROBE after `SETUP_CYC` cycles.
- STROBE to LATCH when the host acknowledge is high.
- LATCH to TURN when the host acknowledge is low.
- STROBE or LATCH to TURN when the request goes high (abort).
- TURN to FINISH after `TURN_CYC` cycles.
- FINISH to IDLE.

Top module: `ecp_rev_tx`

## Requirements
- R1: After reset `ack_rev_n`=1, `periph_clk`=1, `periph_ack`=0, `bus_oe`=0, `done`=0 and `in_ready`=1.
- R2: `in_ready` is high only in IDLE, and a byte is taken only on a clock where `in_valid` and `in_ready` are both high. An `in_valid` offered during a transfer does not change the byte on the bus.
- R3: A byte taken while the synchronized `rev_req_n` is high gives `done`=1 with `done_status`=2'b01 on the edge that takes it. `ack_rev_n` stays 1 and `bus_oe` stays 0.
- R4: A byte taken while the synchronized `rev_req_n` is low drives `ack_rev_n` low on the accepting edge. `bus_oe` rises with the byte on `bus_out` one edge later. `periph_clk` falls exactly `SETUP_CYC` edges after `bus_oe` rises.
- R5: While `bus_oe` is high, `periph_ack` is 1 for a data byte (`in_cmd`=0) and 0 for a command byte (`in_cmd`=1). Both `periph_ack` and `bus_out` hold steady.
- R6: `periph_clk` stays low until the synchronized `host_ack` is high and then rises. The byte remains driven with `bus_oe`=1 across the rise.
- R7: With `periph_clk` high, a low synchronized `host_ack` drops `bus_oe` and `periph_ack` on one edge. `ack_rev_n` then rises `TURN_CYC` edges later, together with `done`=1 and `done_status`=2'b00.
- R8: A synchronized `rev_req_n` high in STROBE or LATCH drops `bus_oe` and raises `periph_clk` on the next edge. `ack_rev_n` then rises `TURN_CYC` edges later with `done`=1 and `done_status`=2'b10.
- R9: `bus_oe` is high only while `ack_rev_n` is low. `bus_oe` is low for at least one full clock before `ack_rev_n` rises.
- R10: A change on `host_ack` or `rev_req_n` acts on the pins `SYNC_STAGES`+1 edges after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Block idle, can take a byte |
| in_data | input | DATA_W | Byte to send |
| in_cmd | input | 1 | 1 = command byte, 0 = data byte |
| rev_req_n | input | 1 | Host reverse request, active low |
| host_ack | input | 1 | Host acknowledge |
| ack_rev_n | output | 1 | Reverse acknowledge, active low |
| periph_ack | output | 1 | Data (1) / command (0) select while presenting |
| periph_clk | output | 1 | Peripheral strobe, low = byte valid |
| bus_out | output | DATA_W | Value for the data bus drivers |
| bus_oe | output | 1 | Data bus driver enable |
| done | output | 1 | One-cycle end-of-byte pulse |
| done_status | output | 2 | 00 sent, 01 refused, 10 aborted |

## Verification
The bench builds the block with `SETUP_CYC`=3, `TURN_CYC`=2 and `SYNC_STAGES`=3 instead of the defaults. With these values the setup and turnaround timers each count through several values rather than expiring on their first cycle. The three-flop synchronizer path is also exercised, so an off-by-one in any of these delays shows up in the measured edge counts. The bench mixes random bytes, flags, host delays and outcomes (sent, refused, aborted in either wait state) with directed cases for each outcome.

// File: rtl/ecp_rev_tx_pkg.sv
package ecp_rev_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REFUSE,
        ST_CLAIM,
        ST_PRESENT,
        ST_STROBE,
        ST_LATCH,
        ST_TURN,
        ST_FINISH
    } rtx_state_t;

    typedef enum logic [1:0] {
        RES_SENT    = 2'b00,
        RES_REFUSED = 2'b01,
        RES_ABORTED = 2'b10
    } rtx_result_t;

    typedef struct packed {
        logic ack_rev_n;
        logic periph_ack;
        logic periph_clk;
        logic bus_oe;
    } rtx_pins_t;

    localparam rtx_pins_t PINS_IDLE = '{ack_rev_n: 1'b1, periph_ack: 1'b0,
                                        periph_clk: 1'b1, bus_oe: 1'b0};

endpackage

// File: rtl/ecp_rev_tx_sync.sv
module ecp_rev_tx_sync #(
    parameter int               WIDTH   = 2,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (STAGES == 1) begin : g_single
            logic flop;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) flop <= RST_VAL[i];
                else        flop <= d[i];
            end
            assign q[i] = flop;
        end else begin : g_chain
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
                else        chain <= {chain[STAGES-2:0], d[i]};
            end
            assign q[i] = chain[STAGES-1];
        end
    end

endmodule

// File: rtl/ecp_rev_tx_timer.sv
module ecp_rev_tx_timer #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/ecp_rev_tx_fsm.sv
module ecp_rev_tx_fsm
    import ecp_rev_tx_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int SETUP_CYC = 2,
    parameter int TURN_CYC  = 1,
    parameter int TW        = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_cmd,
    input  logic              req_n_s,
    input  logic              hack_s,
    input  logic              tmr_expired,
    output logic              in_ready,
    output logic              tmr_load,
    output logic [TW-1:0]     tmr_val,
    output rtx_pins_t         pins,
    output logic [DATA_W-1:0] bus_out,
    output logic              done,
    output logic [1:0]        done_status
);

    rtx_state_t        state, state_nx;
    logic              accept;
    logic [DATA_W-1:0] byte_q;
    logic              cmd_q;
    logic              abort_q;

    // next-state decode
    always_comb begin
        state_nx = state;
        accept   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (in_valid) begin
                    accept   = 1'b1;
                    state_nx = req_n_s ? ST_REFUSE : ST_CLAIM;
                end
            end
            ST_REFUSE:  state_nx = ST_IDLE;
            ST_CLAIM:   state_nx = ST_PRESENT;
            ST_PRESENT: if (tmr_expired) state_nx = ST_STROBE;
            ST_STROBE: begin
                if (req_n_s)     state_nx = ST_TURN;
                else if (hack_s) state_nx = ST_LATCH;
            end
            ST_LATCH: begin
                if (req_n_s || !hack_s) state_nx = ST_TURN;
            end
            ST_TURN:    if (tmr_expired) state_nx = ST_FINISH;
            ST_FINISH:  state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // state register with captured byte and abort flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            byte_q  <= '0;
            cmd_q   <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (accept) begin
                byte_q  <= in_data;
                cmd_q   <= in_cmd;
                abort_q <= 1'b0;
            end else if ((state == ST_STROBE || state == ST_LATCH) && req_n_s) begin
                abort_q <= 1'b1;
            end
        end
    end

    assign in_ready = (state == ST_IDLE);

    assign tmr_load = (state_nx != state) &&
                      (state_nx == ST_PRESENT || state_nx == ST_TURN);
    assign tmr_val  = (state_nx == ST_PRESENT) ? TW'(SETUP_CYC - 1) : TW'(TURN_CYC - 1);

    // registered pin outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pins        <= PINS_IDLE;
            bus_out     <= '0;
            done        <= 1'b0;
            done_status <= RES_SENT;
        end else begin
            pins    <= PINS_IDLE;
            bus_out <= '0;
            done    <= 1'b0;
            unique case (state_nx)
                ST_IDLE: ;
                ST_REFUSE: begin
                    done        <= 1'b1;
                    done_status <= RES_REFUSED;
                end
                ST_CLAIM: pins.ack_rev_n <= 1'b0;
                ST_PRESENT, ST_STROBE, ST_LATCH: begin
                    pins.ack_rev_n  <= 1'b0;
                    pins.bus_oe     <= 1'b1;
                    pins.periph_ack <= ~cmd_q;
                    pins.periph_clk <= (state_nx != ST_STROBE);
                    bus_out         <= byte_q;
                end
                ST_TURN: pins.ack_rev_n <= 1'b0;
                ST_FINISH: begin
                    done        <= 1'b1;
                    done_status <= abort_q ? RES_ABORTED : RES_SENT;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ecp_rev_tx.sv
module ecp_rev_tx
    import ecp_rev_tx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SETUP_CYC   = 2,
    parameter int TURN_CYC    = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_cmd,
    input  logic              rev_req_n,
    input  logic              host_ack,
    output logic              ack_rev_n,
    output logic              periph_ack,
    output logic              periph_clk,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic              done,
    output logic [1:0]        done_status
);

    localparam int TMAX = (SETUP_CYC > TURN_CYC) ? SETUP_CYC : TURN_CYC;
    localparam int TW   = $clog2(TMAX + 1);

    logic [1:0]    sync_q;
    logic          tmr_load, tmr_expired;
    logic [TW-1:0] tmr_val;
    rtx_pins_t     pins;

    // bit 1: reverse request (idles high), bit 0: host acknowledge (idles low)
    ecp_rev_tx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({rev_req_n, host_ack}),
        .q     (sync_q)
    );

    ecp_rev_tx_timer #(.CW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    ecp_rev_tx_fsm #(
        .DATA_W    (DATA_W),
        .SETUP_CYC (SETUP_CYC),
        .TURN_CYC  (TURN_CYC),
        .TW        (TW)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .in_cmd      (in_cmd),
        .req_n_s     (sync_q[1]),
        .hack_s      (sync_q[0]),
        .tmr_expired (tmr_expired),
        .in_ready    (in_ready),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .pins        (pins),
        .bus_out     (bus_out),
        .done        (done),
        .done_status (done_status)
    );

    assign ack_rev_n  = pins.ack_rev_n;
    assign periph_ack = pins.periph_ack;
    assign periph_clk = pins.periph_clk;
    assign bus_oe     = pins.bus_oe;

endmodule

// File: rtl/ecp_rev_tx_chk.sv
module ecp_rev_tx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              ack_rev_n,
    input logic              periph_ack,
    input logic              periph_clk,
    input logic [DATA_W-1:0] bus_out,
    input logic              bus_oe,
    input logic              done,
    input logic [1:0]        done_status
);

    AST_OE_NEEDS_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> !ack_rev_n);  // R9

    AST_TURNAROUND_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_rev_n) |-> (!bus_oe && !$past(bus_oe)));  // R9

    AST_CLAIM_BEFORE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe) |-> !$past(ack_rev_n));  // R4

    AST_STROBE_ON_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !periph_clk |-> (bus_oe && !ack_rev_n));  // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (ack_rev_n && !bus_oe && periph_clk && !periph_ack));  // R2

    AST_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && $past(bus_oe)) |-> ($stable(bus_out) && $stable(periph_ack)));  // R5

    AST_DONE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ack_rev_n && !bus_oe && done_status != 2'b11));  // R7

endmodule

bind ecp_rev_tx ecp_rev_tx_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/ecp_rev_tx_bench.sv
`timescale 1ns/1ps
module ecp_rev_tx_bench;

    localparam int DW    = 8;
    localparam int SETUP = 3;
    localparam int TURN  = 2;
    localparam int SYNC  = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid, in_ready, in_cmd;
    logic [DW-1:0] in_data;
    logic          rev_req_n, host_ack;
    logic          ack_rev_n, periph_ack, periph_clk, bus_oe, done;
    logic [DW-1:0] bus_out;
    logic [1:0]    done_status;

    int nchk = 0;
    int nbad = 0;

    always #2.5 clk = ~clk;

    ecp_rev_tx #(.DATA_W(DW), .SETUP_CYC(SETUP), .TURN_CYC(TURN), .SYNC_STAGES(SYNC)) u_ecp_rev_tx (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_cmd(in_cmd), .rev_req_n(rev_req_n), .host_ack(host_ack),
        .ack_rev_n(ack_rev_n), .periph_ack(periph_ack), .periph_clk(periph_clk),
        .bus_out(bus_out), .bus_oe(bus_oe), .done(done), .done_status(done_status)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic exp_select(input logic cmd);
        return cmd ? 1'b0 : 1'b1;
    endfunction

    function automatic logic [1:0] exp_result(input int kind);
        case (kind)
            1:       return 2'b01;
            2, 3:    return 2'b10;
            default: return 2'b00;
        endcase
    endfunction

    // counts edges until the chosen output reaches val
    task automatic wait_sig(input int sel, input logic val, output int n);
        logic cur;
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            case (sel)
                0:       cur = periph_clk;
                1:       cur = bus_oe;
                default: cur = ack_rev_n;
            endcase
            if (cur == val) break;
            if (n > 500) begin
                chk("wait timeout", n, 0);
                break;
            end
        end
    endtask

    // kind: 0 sent, 1 refused, 2 abort while strobe low, 3 abort while latched
    task automatic run_txn(input int kind, input logic [DW-1:0] data, input logic cmd,
                           input int d1, input int d2);
        int n;
        @(negedge clk);
        rev_req_n = (kind == 1);
        host_ack  = 1'b0;
        repeat (SYNC + 2) @(negedge clk);
        chk("R2 ready in idle", in_ready, 1);
        in_valid = 1'b1;
        in_data  = data;
        in_cmd   = cmd;
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = DW'($urandom);
        if (kind == 1) begin
            chk("R3 done on refuse", done, 1);
            chk("R3 refused code", done_status, exp_result(kind));
            chk("R3 no claim", ack_rev_n, 1);
            chk("R3 bus idle", bus_oe, 0);
            @(negedge clk);
            chk("R3 still unclaimed", ack_rev_n, 1);
            return;
        end
        chk("R4 claim on accept", ack_rev_n, 0);
        chk("R4 bus not yet driven", bus_oe, 0);
        chk("R2 busy not ready", in_ready, 0);
        wait_sig(1, 1'b1, n);
        chk("R4 drive after claim", n, 1);
        wait_sig(0, 1'b0, n);
        chk("R4 setup cycles", n, SETUP);
        chk("R4 byte on bus", bus_out, data);
        chk("R5 select level", periph_ack, exp_select(cmd));
        if (kind == 2) begin
            rev_req_n = 1'b1;
            wait_sig(1, 1'b0, n);
            chk("R8 abort latency", n, SYNC + 1);
            chk("R8 strobe released", periph_clk, 1);
            wait_sig(2, 1'b1, n);
            chk("R8 turnaround", n, TURN);
            chk("R8 done", done, 1);
            chk("R8 abort code", done_status, exp_result(kind));
            return;
        end
        // R2: an offer during the transfer must not disturb the bus
        in_valid = 1'b1;
        in_data  = ~data;
        in_cmd   = ~cmd;
        repeat (d1) @(negedge clk);
        in_valid = 1'b0;
        chk("R6 strobe held low", periph_clk, 0);
        host_ack = 1'b1;
        wait_sig(0, 1'b1, n);
        chk("R10 ack sync latency", n, SYNC + 1);
        chk("R6 byte kept", bus_out, data);
        chk("R2 busy offer ignored", periph_ack, exp_select(cmd));
        chk("R6 bus still driven", bus_oe, 1);
        if (kind == 3) begin
            rev_req_n = 1'b1;
            wait_sig(1, 1'b0, n);
            chk("R8 abort latency latched", n, SYNC + 1);
            wait_sig(2, 1'b1, n);
            chk("R8 turnaround latched", n, TURN);
            chk("R8 abort code latched", done_status, exp_result(kind));
            host_ack = 1'b0;
            return;
        end
        repeat (d2) @(negedge clk);
        host_ack = 1'b0;
        wait_sig(1, 1'b0, n);
        chk("R7 release latency", n, SYNC + 1);
        chk("R7 select dropped", periph_ack, 0);
        chk("R9 claim held past release", ack_rev_n, 0);
        wait_sig(2, 1'b1, n);
        chk("R9 turnaround cycles", n, TURN);
        chk("R7 done", done, 1);
        chk("R7 sent code", done_status, exp_result(kind));
    endtask

    task automatic summary;
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
        $finish;
    end

    initial begin
        int seed_val;
        seed_val  = $urandom(32'h5eed);
        rst_n     = 1'b0;
        in_valid  = 1'b0;
        in_data   = '0;
        in_cmd    = 1'b0;
        rev_req_n = 1'b1;
        host_ack  = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ack_rev_n", ack_rev_n, 1);
        chk("R1 periph_clk", periph_clk, 1);
        chk("R1 periph_ack", periph_ack, 0);
        chk("R1 bus_oe", bus_oe, 0);
        chk("R1 done", done, 0);
        chk("R1 in_ready", in_ready, 1);

        run_txn(0, 8'hA5, 1'b0, 0, 0);
        run_txn(0, 8'h3C, 1'b1, 4, 2);
        run_txn(1, 8'hFF, 1'b0, 0, 0);
        run_txn(2, 8'h11, 1'b1, 0, 0);
        run_txn(3, 8'h00, 1'b0, 1, 0);
        run_txn(0, 8'h81, 1'b0, 0, 5);

        for (int i = 0; i < 60; i++) begin
            int r, kind;
            r = $urandom_range(0, 9);
            kind = (r == 0) ? 1 : (r == 1) ? 2 : (r == 2) ? 3 : 0;
            run_txn(kind, DW'($urandom), 1'($urandom), $urandom_range(0, 6), $urandom_range(0, 6));
        end

        repeat (4) @(negedge clk);
        summary();
        $finish;
    end

endmodule